// File: doc/BRIEF.md
# Serial DAC Input Register Logic

This block is the digital front end of a 16-bit serial-input converter. It runs in a fast system clock domain. The raw pins for chip select, serial clock, data, deferred-load strobe and clear are oversampled there. Bits are collected into a shift register. A complete word goes into an input latch, and from there into the DAC register, whose contents drive the output code bus.

There are two update styles. In the first, the load strobe is held low and the DAC register takes the word as soon as chip select rises. In the second, the load strobe is held high during the transfer. The word then waits in the latch until the strobe is driven low while chip select is high, which lets several converters that share the strobe change their outputs together.

The code bus is a plain level. The converter core samples it whenever it likes, so the bus has no handshake and no back-pressure. Instead, a one-cycle `code_updated` pulse marks each write of the DAC register. A parameter chooses the clear and reset code: midscale (16'h8000) or zero. The bad conditions, a wrong-length frame and a misplaced load strobe, raise sticky flags. These flags are cleared only by reset.

Top module: `sdac_front`

## Requirements
- R1: While `cs_n_pin` is low, one data bit is taken on each rising edge of `sclk_pin`, most significant bit first. A pause of any length between the two bytes of a word leaves the bit count unchanged.
- R2: With `load_n_pin` low, a frame of exactly 16 rising serial-clock edges followed by a rise of `cs_n_pin` writes that word to `code_out`.
- R3: A frame with 1 to 15 serial-clock edges does not change `code_out` and sets `len_err`, which then stays set until reset. A chip-select pulse with no serial-clock edge changes nothing and sets no flag.
- R4: A frame with more than 16 serial-clock edges is discarded and sets `len_err`.
- R5: With `load_n_pin` high when chip select rises, `code_out` keeps its value. The held word reaches `code_out` once `load_n_pin` is low while `cs_n_pin` is high, and never while `cs_n_pin` is low.
- R6: A falling edge of `load_n_pin` while `cs_n_pin` is low sets the sticky `proto_err`. The word of that frame and any word still waiting are both dropped.
- R7: While `clr_n_pin` is low, `code_out` equals the reset code (16'h8000 when MIDSCALE_RST=1, 16'h0000 when it is 0), and completed words are ignored.
- R8: After reset, `code_out` holds the reset code, and `code_updated`, `len_err` and `proto_err` are 0.
- R9: `code_updated` is high for exactly one cycle each time the DAC register is written: on a load, and on the falling edge of clear. `code_out` never changes without it.
- R10: All pins pass through two synchronizer flops. A change of `code_out` shows in the third system clock cycle after the pin edge that caused it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8 times the serial clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n_pin | input | 1 | Active-low chip select, asynchronous |
| sclk_pin | input | 1 | Serial clock, asynchronous |
| din_pin | input | 1 | Serial data |
| load_n_pin | input | 1 | Active-low deferred load strobe |
| clr_n_pin | input | 1 | Active-low clear to the reset code |
| code_out | output | WORD_W | DAC register contents |
| code_updated | output | 1 | One-cycle pulse on each DAC register write |
| len_err | output | 1 | Sticky: a frame of wrong length was seen |
| proto_err | output | 1 | Sticky: the load strobe fell during a frame |

## Verification
The bench builds two copies of the block from the same pins. One has the midscale reset code and one has the zero reset code, so every clear and reset value is checked against both constants, while the shared data path must keep the two identical. Both use a 16-bit word and two synchronizer stages. This keeps the three-cycle latency and the 16- and 17-edge boundaries at fixed, countable positions. A serial clock at one tenth of the system rate exercises the edge detectors with a wide margin.

// File: rtl/sdac_pkg.sv
package sdac_pkg;

  // Synchronized view of the five input pins.
  typedef struct packed {
    logic cs_n;
    logic sclk;
    logic din;
    logic load_n;
    logic clr_n;
  } pins_t;

  localparam int unsigned PIN_N = $bits(pins_t);

  // Idle levels, used as the synchronizer reset value so that no false edge follows reset.
  localparam pins_t PINS_IDLE = '{cs_n: 1'b1, sclk: 1'b0, din: 1'b0, load_n: 1'b1, clr_n: 1'b1};

endpackage

// File: rtl/sdac_sync.sv
module sdac_sync #(
  parameter int unsigned W      = 5,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] INIT  = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(STAGES); i++) stg_q[i] <= INIT;
    end else begin
      stg_q[0] <= d;
      for (int i = 1; i < int'(STAGES); i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q = stg_q[STAGES-1];

  initial begin
    if (STAGES < 2) $error("sdac_sync needs at least two stages");
  end

endmodule

// File: rtl/sdac_shifter.sv
module sdac_shifter #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cs_low,
  input  logic         cs_rise,
  input  logic         sclk_rise,
  input  logic         din,
  output logic [W-1:0] word,
  output logic         word_ok,
  output logic         len_err
);

  localparam int unsigned CNT_W = $clog2(W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(W);

  logic [W-1:0]     shreg_q;
  logic [CNT_W-1:0] cnt_q;
  logic             ovf_q;
  logic             len_err_q;
  logic             bad_frame;

  assign word_ok   = cs_rise & (cnt_q == FULL) & ~ovf_q;
  assign bad_frame = cs_rise & (cnt_q != '0) & ~word_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q   <= '0;
      cnt_q     <= '0;
      ovf_q     <= 1'b0;
      len_err_q <= 1'b0;
    end else begin
      if (cs_low) begin
        if (sclk_rise) begin
          shreg_q <= {shreg_q[W-2:0], din};
          if (cnt_q == FULL) ovf_q <= 1'b1;
          else               cnt_q <= cnt_q + 1'b1;
        end
      end else begin
        cnt_q <= '0;
        ovf_q <= 1'b0;
      end
      if (bad_frame) len_err_q <= 1'b1;
    end
  end

  assign word    = shreg_q;
  assign len_err = len_err_q;

  // R3: a short frame raises the length flag on the next cycle
  a_r3_short_frame_flagged: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise && cnt_q != '0 && cnt_q != FULL) |=> len_err_q);

  // R4: an overrun frame is never offered to the DAC register
  a_r4_overrun_no_word: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise && ovf_q) |-> !word_ok);

  // R1: the bit count never passes one word
  a_r1_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= FULL);

endmodule

// File: rtl/sdac_dacreg.sv
module sdac_dacreg #(
  parameter int unsigned  W        = 16,
  parameter logic [W-1:0] RST_CODE = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cs_low,
  input  logic         cs_rise,
  input  logic         load_n,
  input  logic         load_fall,
  input  logic         clr_n,
  input  logic         clr_fall,
  input  logic [W-1:0] word,
  input  logic         word_ok,
  output logic [W-1:0] code,
  output logic         updated,
  output logic         proto_err
);

  logic [W-1:0] latch_q;
  logic [W-1:0] code_q;
  logic         pend_q;
  logic         taint_q;
  logic         proto_q;
  logic         upd_q;
  logic         viol;
  logic         take_word;
  logic         load_now;
  logic         load_late;

  assign viol      = cs_low & load_fall;
  assign take_word = word_ok & ~taint_q & clr_n;
  assign load_now  = take_word & ~load_n;
  assign load_late = ~take_word & ~cs_low & ~load_n & pend_q & clr_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= RST_CODE;
      code_q  <= RST_CODE;
      pend_q  <= 1'b0;
      taint_q <= 1'b0;
      proto_q <= 1'b0;
      upd_q   <= 1'b0;
    end else begin
      if (!cs_low)   taint_q <= 1'b0;
      else if (viol) taint_q <= 1'b1;
      if (viol) proto_q <= 1'b1;

      if (!clr_n) begin
        code_q <= RST_CODE;
        pend_q <= 1'b0;
        upd_q  <= clr_fall;
      end else begin
        upd_q <= load_now | load_late;
        if (take_word) latch_q <= word;
        if (load_now)       code_q <= word;
        else if (load_late) code_q <= latch_q;
        if (viol || load_now || load_late) pend_q <= 1'b0;
        else if (take_word)                pend_q <= 1'b1;
      end
    end
  end

  assign code      = code_q;
  assign updated   = upd_q;
  assign proto_err = proto_q;

  // R9: the output code never moves without the pulse
  a_r9_change_has_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (code_q != $past(code_q)) |-> upd_q);

  // R9: the pulse lasts one cycle
  a_r9_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    upd_q |=> !upd_q);

  // R7: clear forces the reset code
  a_r7_clear_forces: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n |=> (code_q == RST_CODE));

  // R6: a frame with a misplaced strobe leaves the code alone
  a_r6_tainted_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (word_ok && taint_q && clr_n) |=> $stable(code_q));

  // R5: no load while chip select is low
  a_r5_no_load_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_low && clr_n) |=> !upd_q);

endmodule

// File: rtl/sdac_front.sv
module sdac_front #(
  parameter int unsigned WORD_W       = 16,
  parameter bit          MIDSCALE_RST = 1'b1,
  parameter int unsigned SYNC_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n_pin,
  input  logic              sclk_pin,
  input  logic              din_pin,
  input  logic              load_n_pin,
  input  logic              clr_n_pin,
  output logic [WORD_W-1:0] code_out,
  output logic              code_updated,
  output logic              len_err,
  output logic              proto_err
);

  import sdac_pkg::*;

  localparam logic [WORD_W-1:0] RST_CODE =
    MIDSCALE_RST ? {1'b1, {(WORD_W-1){1'b0}}} : '0;

  pins_t raw;
  pins_t syn;
  logic  cs_p, sclk_p, load_p, clr_p;
  logic  cs_rise, cs_low, sclk_rise, load_fall, clr_fall;
  logic [WORD_W-1:0] word;
  logic              word_ok;

  assign raw = '{cs_n: cs_n_pin, sclk: sclk_pin, din: din_pin,
                 load_n: load_n_pin, clr_n: clr_n_pin};

  sdac_sync #(.W(PIN_N), .STAGES(SYNC_STAGES), .INIT(PINS_IDLE)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw), .q(syn)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_p   <= PINS_IDLE.cs_n;
      sclk_p <= PINS_IDLE.sclk;
      load_p <= PINS_IDLE.load_n;
      clr_p  <= PINS_IDLE.clr_n;
    end else begin
      cs_p   <= syn.cs_n;
      sclk_p <= syn.sclk;
      load_p <= syn.load_n;
      clr_p  <= syn.clr_n;
    end
  end

  assign cs_low    = ~syn.cs_n;
  assign cs_rise   = syn.cs_n & ~cs_p;
  assign sclk_rise = syn.sclk & ~sclk_p;
  assign load_fall = ~syn.load_n & load_p;
  assign clr_fall  = ~syn.clr_n & clr_p;

  sdac_shifter #(.W(WORD_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .cs_low(cs_low), .cs_rise(cs_rise),
    .sclk_rise(sclk_rise), .din(syn.din),
    .word(word), .word_ok(word_ok), .len_err(len_err)
  );

  sdac_dacreg #(.W(WORD_W), .RST_CODE(RST_CODE)) u_dreg (
    .clk(clk), .rst_n(rst_n), .cs_low(cs_low), .cs_rise(cs_rise),
    .load_n(syn.load_n), .load_fall(load_fall),
    .clr_n(syn.clr_n), .clr_fall(clr_fall),
    .word(word), .word_ok(word_ok),
    .code(code_out), .updated(code_updated), .proto_err(proto_err)
  );

endmodule

// File: tb/sdac_front_tb.sv
module sdac_front_tb;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sclk = 1'b0, din = 1'b0, load_n = 1'b0, clr_n = 1'b1;

  logic [15:0] code_m, code_z;
  logic upd_m, upd_z, len_m, len_z, pro_m, pro_z;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  sdac_front #(.MIDSCALE_RST(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n_pin(cs_n), .sclk_pin(sclk), .din_pin(din),
    .load_n_pin(load_n), .clr_n_pin(clr_n),
    .code_out(code_m), .code_updated(upd_m), .len_err(len_m), .proto_err(pro_m)
  );

  sdac_front #(.MIDSCALE_RST(1'b0)) u_dut_z (
    .clk(clk), .rst_n(rst_n), .cs_n_pin(cs_n), .sclk_pin(sclk), .din_pin(din),
    .load_n_pin(load_n), .clr_n_pin(clr_n),
    .code_out(code_z), .code_updated(upd_z), .len_err(len_z), .proto_err(pro_z)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  localparam logic [4:0] IDLE = 5'b10011;  // {cs, sclk, din, load, clr}
  logic [4:0] d1, d2, d3;
  logic [15:0] m_code, m_code_z, m_word, m_latch;
  logic m_upd, m_len, m_proto, m_taint, m_pend;
  int m_cnt;

  always @(posedge clk) begin
    if (!rst_n) begin
      d1 = IDLE; d2 = IDLE; d3 = IDLE;
      m_code = 16'h8000; m_code_z = 16'h0000; m_word = '0; m_latch = '0;
      m_upd = 0; m_len = 0; m_proto = 0; m_taint = 0; m_pend = 0; m_cnt = 0;
    end else begin
      logic good;
      good  = 1'b0;
      m_upd = 1'b0;
      if (d2[4] && !d3[4]) begin
        if (m_cnt == 16) good = !m_taint;
        else if (m_cnt != 0) m_len = 1'b1;
      end
      if (!d2[0]) begin
        m_code = 16'h8000; m_code_z = 16'h0000; m_pend = 0; m_upd = d3[0];
      end else if (good) begin
        m_latch = m_word;
        if (!d2[1]) begin
          m_code = m_word; m_code_z = m_word; m_pend = 0; m_upd = 1;
        end else m_pend = 1;
      end else if (d2[4] && !d2[1] && m_pend) begin
        m_code = m_latch; m_code_z = m_latch; m_pend = 0; m_upd = 1;
      end
      if (!d2[4]) begin
        if (!d2[1] && d3[1]) begin m_proto = 1; m_taint = 1; m_pend = 0; end
        if (d2[3] && !d3[3]) begin m_word = {m_word[14:0], d2[2]}; m_cnt++; end
      end else begin
        m_cnt = 0; m_taint = 0;
      end
      d3 = d2; d2 = d1; d1 = {cs_n, sclk, din, load_n, clr_n};
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R2 code", code_m, m_code);
      chk("R7 code zero-variant", code_z, m_code_z);
      chk("R9 pulse", upd_m, m_upd);
      chk("R9 pulse zero-variant", upd_z, m_upd);
      chk("R3 len_err", len_m, m_len);
      chk("R4 len_err zero-variant", len_z, m_len);
      chk("R6 proto_err", pro_m, m_proto);
      chk("R6 proto_err zero-variant", pro_z, m_proto);
    end
  end

  // ---------------- stimulus ----------------
  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic shift_bits(input logic [31:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      din = v[i]; tick(5); sclk = 1'b1; tick(5); sclk = 1'b0;
    end
  endtask

  task automatic frame(input logic [31:0] v, input int n, input bit split);
    cs_n = 1'b0; tick(5);
    if (split && n == 16) begin
      shift_bits(v >> 8, 8); tick(20); shift_bits(v, 8);
    end else shift_bits(v, n);
    tick(5); cs_n = 1'b1; tick(12);
  endtask

  task automatic finish_run;
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(2);
    // R8: reset values in both variants
    chk("R8 midscale reset", code_m, 16'h8000);
    chk("R8 zero reset", code_z, 16'h0000);
    chk("R8 flags", {upd_m, len_m, pro_m}, 3'b000);
    tick(10);

    // R1, R2: one-piece word, strobe held low
    frame(32'hA5C3, 16, 1'b0);
    chk("R2 direct load", code_m, 16'hA5C3);
    chk("R1 zero-variant same word", code_z, 16'hA5C3);

    // R1: two bytes with a pause between them
    frame(32'h1234, 16, 1'b1);
    chk("R1 split word", code_m, 16'h1234);

    // R3: empty chip-select pulse has no effect
    cs_n = 1'b0; tick(10); cs_n = 1'b1; tick(12);
    chk("R3 empty frame code", code_m, 16'h1234);
    chk("R3 empty frame no flag", len_m, 1'b0);

    // R3: short frame
    frame(32'h1FF, 9, 1'b0);
    chk("R3 short frame code", code_m, 16'h1234);
    chk("R3 short frame flag", len_m, 1'b1);

    // R4: overlong frame
    frame(32'h1FFFF, 17, 1'b0);
    chk("R4 long frame code", code_m, 16'h1234);

    // R5: deferred load
    load_n = 1'b1; tick(12);
    frame(32'hBEEF, 16, 1'b0);
    chk("R5 held word not loaded", code_m, 16'h1234);
    load_n = 1'b0; tick(12);
    chk("R5 strobe loads held word", code_m, 16'hBEEF);

    // R6: strobe falls inside a frame
    load_n = 1'b1; tick(12);
    cs_n = 1'b0; tick(5); load_n = 1'b0; tick(5);
    shift_bits(32'h0F0F, 16);
    tick(5); cs_n = 1'b1; tick(20);
    chk("R6 flag set", pro_m, 1'b1);
    chk("R6 word dropped", code_m, 16'hBEEF);

    // R7: clear, and words ignored while clear is low
    clr_n = 1'b0; tick(12);
    chk("R7 midscale clear", code_m, 16'h8000);
    chk("R7 zero clear", code_z, 16'h0000);
    frame(32'h7777, 16, 1'b0);
    chk("R7 word ignored", code_m, 16'h8000);
    clr_n = 1'b1; tick(12);
    chk("R7 release keeps code", code_m, 16'h8000);

    // R10, R9: exact latency from chip-select rise
    cs_n = 1'b0; tick(5);
    shift_bits(32'h4C21, 16);
    tick(5);
    cs_n = 1'b1;
    tick(2);
    chk("R10 not yet after two clocks", code_m, 16'h8000);
    tick(1);
    chk("R10 third clock", code_m, 16'h4C21);
    chk("R9 pulse high", upd_m, 1'b1);
    tick(1);
    chk("R9 pulse one cycle", upd_m, 1'b0);
    tick(10);

    finish_run();
  end

endmodule